// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a dual-plane flash array controller and turns the stream of bus write cycles into operation requests. Each write cycle is presented for one clock with `wr_en` high. The decoder matches the unlock-prefixed command sequences for word program, chip erase, sector erase, sector lockout, identification entry and exit, and fast-program (bypass) entry. It also matches the single-cycle erase suspend, erase resume and identification exit writes. When a sequence completes, it emits a one-clock request pulse that carries an operation code and the address and data of the closing write. The embedded program and erase engine consumes that pulse and reports its own activity back through two busy inputs.

Two mode flags are held. The identification flag turns on a read path that returns the manufacturer code, the device code and the lockout bit of any sector. The bypass flag makes every write a program request. Bypass entry is accepted only while `vpp_high` is set. A reset or a falling edge of `vpp_high` clears the flag. Lockout requests set a per-sector lock bit inside the block. Sectors are uniform, each 2^SECT_SHIFT words.

State machine states:
- `S_IDLE`: read mode.
- `S_UNLK1`: the first unlock write has been seen.
- `S_UNLK2`: the full unlock prefix has been seen.
- `S_PROG`: waiting for the program address and data.
- `S_ERA1`: the erase-setup code has been seen.
- `S_ERA2`: the second first-unlock write has been seen.
- `S_ERA3`: the second full prefix has been seen.

State machine transitions:
- Idle to UNLK1.
- UNLK1 to UNLK2.
- UNLK2 to PROG, to ERA1, or back to idle. The return to idle applies the identification entry or exit.
- PROG to idle, issuing a program request.
- ERA1 to ERA2.
- ERA2 to ERA3.
- ERA3 to idle, issuing a chip erase, sector erase or lockout request, or setting bypass.
- Any mismatch returns the machine to idle without issuing a request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid`, `id_mode`, `bypass_mode` and `id_data` are all 0.
- R2: Command cycles compare only address bits 15:0 and data bits 7:0. All other address and data bits are ignored.
- R3: The write sequence 5555/AA, 2AAA/55, 5555/A0, X/D raises `op_valid` for one clock after the fourth write. That pulse has `op_kind`=0 (program), `op_addr`=X and `op_data`=D.
- R4: The writes 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/10 issue `op_kind`=1 (chip erase).
- R5: The same five-write prefix followed by 30 at any address S issues `op_kind`=2 (sector erase) with `op_addr`=S. Followed instead by 40 at S, it issues `op_kind`=3 (sector lock) and sets the lock bit of sector S[ADDR_W-1:SECT_SHIFT].
- R6: The prefix followed by 5555/90 sets `id_mode`. `id_mode` is cleared by the prefix followed by 5555/F0, or by a single F0 written to any address. While `id_mode` is set:
  - `rd_addr`=0 returns MFR_CODE.
  - `rd_addr`=1 returns DEV_CODE.
  - Offset 2 inside a sector returns that sector's lock bit on bit 0, where 1 means locked.
- R7: A single B0 write issues `op_kind`=4 (suspend) only while `busy_sector_erase` is 1; otherwise it is ignored. A single 30 write issues `op_kind`=5 (resume) with the written address, so that the plane is on bits 19:18.
- R8: The erase prefix followed by 5555/A0 sets `bypass_mode` only if `vpp_high` is 1. While bypass is set, every write, including the AA, F0, B0 and 30 codes, issues `op_kind`=0 with its own address and data.
- R9: `bypass_mode` is cleared one clock after `vpp_high` falls, and by reset.
- R10: While `busy_chip_erase` is 1, writes issue nothing and leave the partly entered sequence unchanged.
- R11: A write that does not match the next expected step returns the sequence to idle and issues nothing.
- R12: While `id_mode` is 0, `id_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data |
| busy_sector_erase | input | 1 | Engine is running a sector erase |
| busy_chip_erase | input | 1 | Engine is running a chip erase |
| vpp_high | input | 1 | Programming supply is at the high level |
| rd_addr | input | ADDR_W | Identification read address |
| op_valid | output | 1 | One-clock operation request |
| op_kind | output | 3 | Operation code (0 program, 1 chip erase, 2 sector erase, 3 lock, 4 suspend, 5 resume) |
| op_addr | output | ADDR_W | Address of the closing write |
| op_data | output | DATA_W | Data of the closing write |
| id_mode | output | 1 | Identification mode flag |
| bypass_mode | output | 1 | Fast-program mode flag |
| id_data | output | DATA_W | Identification read data |

## Verification
The bench builds the block with its defaults: 20 address bits, 16 data bits and SECT_SHIFT=15, which gives 32 sectors. With these values, the upper address nibble and upper data byte can be filled with junk to show they are ignored. A lockout in sector 1 can also be told apart from sector 2 through the offset-2 identification read, and bits 19:18 carry the resume plane address. The vector table walks complete and broken sequences. Directed tests then cover:
- the supply-gated bypass entry and exit;
- the suspend gating;
- a chip-erase busy window that falls in the middle of a prefix.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_ADDR_BITS = 16;
    localparam int CMD_DATA_BITS = 8;
    localparam logic [CMD_ADDR_BITS-1:0] ADDR_FIRST  = 16'h5555;
    localparam logic [CMD_ADDR_BITS-1:0] ADDR_SECOND = 16'h2AAA;

    typedef enum logic [3:0] {
        C_AA, C_55, C_A0, C_80, C_10, C_30, C_40, C_90, C_F0, C_B0, C_OTHER
    } cmd_code_t;

    typedef enum logic [2:0] {
        OP_PROGRAM      = 3'd0,
        OP_CHIP_ERASE   = 3'd1,
        OP_SECTOR_ERASE = 3'd2,
        OP_SECTOR_LOCK  = 3'd3,
        OP_SUSPEND      = 3'd4,
        OP_RESUME       = 3'd5
    } op_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_UNLK1, S_UNLK2, S_PROG, S_ERA1, S_ERA2, S_ERA3
    } seq_state_t;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              at_first,
    output logic              at_second,
    output cmd_code_t         code
);

    logic [CMD_ADDR_BITS-1:0] addr_low;
    logic [CMD_DATA_BITS-1:0] data_low;

    assign addr_low  = addr[CMD_ADDR_BITS-1:0];
    assign data_low  = data[CMD_DATA_BITS-1:0];
    assign at_first  = (addr_low == ADDR_FIRST);
    assign at_second = (addr_low == ADDR_SECOND);

    always_comb begin
        unique case (data_low)
            8'hAA:   code = C_AA;
            8'h55:   code = C_55;
            8'hA0:   code = C_A0;
            8'h80:   code = C_80;
            8'h10:   code = C_10;
            8'h30:   code = C_30;
            8'h40:   code = C_40;
            8'h90:   code = C_90;
            8'hF0:   code = C_F0;
            8'hB0:   code = C_B0;
            default: code = C_OTHER;
        endcase
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              at_first,
    input  logic              at_second,
    input  cmd_code_t         code,
    input  logic              busy_sector_erase,
    input  logic              busy_chip_erase,
    input  logic              vpp_high,
    output logic              op_valid,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic              bypass_mode
);

    seq_state_t state, state_nxt;
    logic       fire;
    op_kind_t   kind_nxt;
    logic       id_nxt, byp_nxt;
    logic       vpp_q;
    logic       take;

    // A write counts only when no chip erase is running (R10).
    assign take = wr_en && !busy_chip_erase;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        kind_nxt  = OP_PROGRAM;
        id_nxt    = id_mode;
        byp_nxt   = bypass_mode;
        if (take) begin
            if (bypass_mode) begin
                fire      = 1'b1;
                state_nxt = S_IDLE;
            end else begin
                state_nxt = S_IDLE;
                unique case (state)
                    S_IDLE: begin
                        if (at_first && code == C_AA) begin
                            state_nxt = S_UNLK1;
                        end else if (code == C_B0) begin
                            fire     = busy_sector_erase;
                            kind_nxt = OP_SUSPEND;
                        end else if (code == C_30) begin
                            fire     = 1'b1;
                            kind_nxt = OP_RESUME;
                        end else if (code == C_F0) begin
                            id_nxt = 1'b0;
                        end
                    end
                    S_UNLK1: begin
                        if (at_second && code == C_55) state_nxt = S_UNLK2;
                    end
                    S_UNLK2: begin
                        if (at_first) begin
                            if (code == C_A0)      state_nxt = S_PROG;
                            else if (code == C_80) state_nxt = S_ERA1;
                            else if (code == C_90) id_nxt = 1'b1;
                            else if (code == C_F0) id_nxt = 1'b0;
                        end
                    end
                    S_PROG: begin
                        fire = 1'b1;
                    end
                    S_ERA1: begin
                        if (at_first && code == C_AA) state_nxt = S_ERA2;
                    end
                    S_ERA2: begin
                        if (at_second && code == C_55) state_nxt = S_ERA3;
                    end
                    S_ERA3: begin
                        if (at_first && code == C_10) begin
                            fire     = 1'b1;
                            kind_nxt = OP_CHIP_ERASE;
                        end else if (at_first && code == C_A0) begin
                            byp_nxt = vpp_high;
                        end else if (code == C_30) begin
                            fire     = 1'b1;
                            kind_nxt = OP_SECTOR_ERASE;
                        end else if (code == C_40) begin
                            fire     = 1'b1;
                            kind_nxt = OP_SECTOR_LOCK;
                        end
                    end
                endcase
            end
        end
        if (vpp_q && !vpp_high) byp_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid    <= 1'b0;
            op_kind     <= OP_PROGRAM;
            op_addr     <= '0;
            op_data     <= '0;
            id_mode     <= 1'b0;
            bypass_mode <= 1'b0;
            vpp_q       <= 1'b0;
        end else begin
            op_valid    <= fire;
            id_mode     <= id_nxt;
            bypass_mode <= byp_nxt;
            vpp_q       <= vpp_high;
            if (fire) begin
                op_kind <= kind_nxt;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/fcd_lock_table.sv
module fcd_lock_table #(
    parameter int              ADDR_W     = 20,
    parameter int              DATA_W     = 16,
    parameter int              SECT_SHIFT = 15,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h00DF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data
);

    localparam int SECT_W   = ADDR_W - SECT_SHIFT;
    localparam int NUM_SECT = 1 << SECT_W;

    logic [NUM_SECT-1:0]   lock_q;
    logic [SECT_W-1:0]     set_sect, rd_sect;
    logic [SECT_SHIFT-1:0] rd_off;

    assign set_sect = set_addr[ADDR_W-1:SECT_SHIFT];
    assign rd_sect  = rd_addr[ADDR_W-1:SECT_SHIFT];
    assign rd_off   = rd_addr[SECT_SHIFT-1:0];

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[s] <= 1'b0;
            else if (set_en && set_sect == SECT_W'(s))
                lock_q[s] <= 1'b1;
        end
    end

    always_comb begin
        id_data = '0;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))
                id_data = MFR_CODE;
            else if (rd_addr == ADDR_W'(1))
                id_data = DEV_CODE;
            else if (rd_off == SECT_SHIFT'(2))
                id_data = DATA_W'(lock_q[rd_sect]);
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter int                DATA_W     = 16,
    parameter int                SECT_SHIFT = 15,
    parameter logic [DATA_W-1:0] MFR_CODE   = 16'h001F,
    parameter logic [DATA_W-1:0] DEV_CODE   = 16'h00DF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy_sector_erase,
    input  logic              busy_chip_erase,
    input  logic              vpp_high,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic              bypass_mode,
    output logic [DATA_W-1:0] id_data
);

    logic      at_first, at_second;
    cmd_code_t code;
    op_kind_t  kind_q;

    fcd_cycle_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .at_first  (at_first),
        .at_second (at_second),
        .code      (code)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .wr_en             (wr_en),
        .wr_addr           (wr_addr),
        .wr_data           (wr_data),
        .at_first          (at_first),
        .at_second         (at_second),
        .code              (code),
        .busy_sector_erase (busy_sector_erase),
        .busy_chip_erase   (busy_chip_erase),
        .vpp_high          (vpp_high),
        .op_valid          (op_valid),
        .op_kind           (kind_q),
        .op_addr           (op_addr),
        .op_data           (op_data),
        .id_mode           (id_mode),
        .bypass_mode       (bypass_mode)
    );

    assign op_kind = kind_q;

    fcd_lock_table #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_SHIFT(SECT_SHIFT),
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (op_valid && kind_q == OP_SECTOR_LOCK),
        .set_addr (op_addr),
        .id_mode  (id_mode),
        .rd_addr  (rd_addr),
        .id_data  (id_data)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy_sector_erase,
    input logic              busy_chip_erase,
    input logic              vpp_high,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] op_data,
    input logic              id_mode,
    input logic              bypass_mode,
    input logic [DATA_W-1:0] id_data
);

    assert_req_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));

    assert_chip_busy_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && busy_chip_erase) |-> !op_valid);

    assert_suspend_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd4) |-> $past(busy_sector_erase));

    assert_bypass_needs_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_mode) |-> $past(vpp_high));

    assert_bypass_all_program_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(bypass_mode)) |-> op_kind == 3'd0);

    assert_bypass_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_high) |=> !bypass_mode);

    assert_id_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> id_data == '0);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy_sector_erase = 1'b0;
    logic        busy_chip_erase = 1'b0;
    logic        vpp_high = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [19:0] op_addr;
    logic [15:0] op_data;
    logic        id_mode, bypass_mode;
    logic [15:0] id_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder uut (.*);

    typedef struct packed {
        logic [19:0] a;
        logic [15:0] d;
        logic        ev;
        logic [2:0]  ek;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        // R3 word program
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAA, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h00A0, 1'b0, 3'd0}, '{20'h12345, 16'hBEEF, 1'b1, 3'd0},
        // R2 upper bits ignored
        '{20'hF5555, 16'h12AA, 1'b0, 3'd0}, '{20'h32AAA, 16'hFF55, 1'b0, 3'd0},
        '{20'h85555, 16'h00A0, 1'b0, 3'd0}, '{20'h00042, 16'h0001, 1'b1, 3'd0},
        // R4 chip erase
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAA, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h0080, 1'b0, 3'd0}, '{20'h05555, 16'h00AA, 1'b0, 3'd0},
        '{20'h02AAA, 16'h0055, 1'b0, 3'd0}, '{20'h05555, 16'h0010, 1'b1, 3'd1},
        // R5 sector erase
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAA, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h0080, 1'b0, 3'd0}, '{20'h05555, 16'h00AA, 1'b0, 3'd0},
        '{20'h02AAA, 16'h0055, 1'b0, 3'd0}, '{20'h48000, 16'h0030, 1'b1, 3'd2},
        // R5 sector lock of sector 1
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAA, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h0080, 1'b0, 3'd0}, '{20'h05555, 16'h00AA, 1'b0, 3'd0},
        '{20'h02AAA, 16'h0055, 1'b0, 3'd0}, '{20'h08123, 16'h0040, 1'b1, 3'd3},
        // R11 broken prefix
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAB, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h00A0, 1'b0, 3'd0}, '{20'h01234, 16'h5678, 1'b0, 3'd0},
        // R11 broken erase tail
        '{20'h05555, 16'h00AA, 1'b0, 3'd0}, '{20'h02AAA, 16'h0055, 1'b0, 3'd0},
        '{20'h05555, 16'h0080, 1'b0, 3'd0}, '{20'h05555, 16'h00AA, 1'b0, 3'd0},
        '{20'h02AAA, 16'h0055, 1'b0, 3'd0}, '{20'h05555, 16'h0020, 1'b0, 3'd0},
        // R7 resume on plane 3
        '{20'hC0000, 16'h0030, 1'b1, 3'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write for one clock; returns at the negedge where its effect shows.
    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prefix6();
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0080);
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
    endtask

    task automatic expect_prog(input string req, input logic [19:0] a, input logic [15:0] d);
        check(req, {31'd0, op_valid}, 32'd1);
        check(req, {29'd0, op_kind}, 32'd0);
        check(req, {12'd0, op_addr}, {12'd0, a});
        check(req, {16'd0, op_data}, {16'd0, d});
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 op_valid", {31'd0, op_valid}, 32'd0);
        check("R1 id_mode", {31'd0, id_mode}, 32'd0);
        check("R1 bypass_mode", {31'd0, bypass_mode}, 32'd0);
        check("R1 id_data", {16'd0, id_data}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].d);
            check($sformatf("table %0d valid", i), {31'd0, op_valid}, {31'd0, VEC[i].ev});
            if (VEC[i].ev) begin
                check($sformatf("table %0d kind", i), {29'd0, op_kind}, {29'd0, VEC[i].ek});
                check($sformatf("table %0d addr", i), {12'd0, op_addr}, {12'd0, VEC[i].a});
                check($sformatf("table %0d data", i), {16'd0, op_data}, {16'd0, VEC[i].d});
            end
        end

        // R6 identification entry and reads
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0090);
        check("R6 id entry", {31'd0, id_mode}, 32'd1);
        rd_addr = 20'h00000; #1 check("R6 mfr", {16'd0, id_data}, 32'h001F);
        rd_addr = 20'h00001; #1 check("R6 dev", {16'd0, id_data}, 32'h00DF);
        rd_addr = 20'h08002; #1 check("R6 lock sector1", {16'd0, id_data}, 32'h0001);
        rd_addr = 20'h10002; #1 check("R6 lock sector2", {16'd0, id_data}, 32'h0000);
        @(negedge clk);
        wr(20'h07777, 16'h00F0);
        check("R6 single exit", {31'd0, id_mode}, 32'd0);
        rd_addr = 20'h00000; #1 check("R12 quiet", {16'd0, id_data}, 32'h0000);
        @(negedge clk);
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0090);
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00F0);
        check("R6 prefix exit", {31'd0, id_mode}, 32'd0);
        check("R6 exit no op", {31'd0, op_valid}, 32'd0);

        // R7 suspend gating
        wr(20'h03333, 16'h00B0);
        check("R7 suspend idle", {31'd0, op_valid}, 32'd0);
        busy_sector_erase = 1'b1;
        wr(20'h03333, 16'h00B0);
        check("R7 suspend", {31'd0, op_valid}, 32'd1);
        check("R7 suspend kind", {29'd0, op_kind}, 32'd4);
        busy_sector_erase = 1'b0;

        // R10 chip erase busy in the middle of a prefix
        wr(20'h05555, 16'h00AA);
        busy_chip_erase = 1'b1;
        wr(20'h00000, 16'h0000);
        check("R10 ignored", {31'd0, op_valid}, 32'd0);
        wr(20'h05555, 16'h0030);
        check("R10 no resume", {31'd0, op_valid}, 32'd0);
        busy_chip_erase = 1'b0;
        wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(20'h00777, 16'h1234);
        expect_prog("R10 prefix kept", 20'h00777, 16'h1234);

        // R8 bypass refused with supply low
        prefix6(); wr(20'h05555, 16'h00A0);
        check("R8 refused", {31'd0, bypass_mode}, 32'd0);
        wr(20'h00100, 16'h00AA);
        check("R8 refused no op", {31'd0, op_valid}, 32'd0);
        vpp_high = 1'b1;
        @(negedge clk);
        prefix6(); wr(20'h05555, 16'h00A0);
        check("R8 entry", {31'd0, bypass_mode}, 32'd1);
        check("R8 entry no op", {31'd0, op_valid}, 32'd0);
        wr(20'h05555, 16'h00AA); expect_prog("R8 AA", 20'h05555, 16'h00AA);
        wr(20'h01000, 16'h00F0); expect_prog("R8 F0", 20'h01000, 16'h00F0);
        busy_sector_erase = 1'b1;
        wr(20'h02000, 16'h00B0); expect_prog("R8 B0", 20'h02000, 16'h00B0);
        busy_sector_erase = 1'b0;
        wr(20'h48000, 16'h0030); expect_prog("R8 30", 20'h48000, 16'h0030);

        // R9 falling supply leaves bypass
        vpp_high = 1'b0;
        @(negedge clk);
        check("R9 vpp fall", {31'd0, bypass_mode}, 32'd0);
        wr(20'h40000, 16'h0030);
        check("R9 resume back", {29'd0, op_kind}, 32'd5);
        vpp_high = 1'b1;
        @(negedge clk);
        prefix6(); wr(20'h05555, 16'h00A0);
        check("R9 reentry", {31'd0, bypass_mode}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset clears", {31'd0, bypass_mode}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule